// File: doc/BRIEF.md
# Graphics Coprocessor Host Register Window

This block is the host-facing side of a 16-bit graphics coprocessor. A host bus with a byte-wide data path reaches every register the coprocessor exposes through a 10-bit byte address. The window holds three things. The first is sixteen 16-bit general registers, with the last one serving as the program counter. The second is a 16-bit status word together with a group of 8-bit control bytes covering banks, screen base, screen mode, configuration, clock, version and cache base. The third is a 512-byte cache memory.

Writing the upper byte of the program counter launches the coprocessor. The launch raises a one-cycle start pulse and sets the running flag in the status word. The running flag stays set until the core reports that it has stopped. The core reports an interrupt through an input. The host sees that interrupt on an output unless the configuration byte masks it. Reading the upper status byte acknowledges the interrupt. The screen-mode byte decides whether the host or the coprocessor owns the cartridge ROM and RAM.

The execution core is outside this block. Simple inputs stand in for it: one reports a stop, one raises an interrupt, and one loads the arithmetic and mode flags. Host reads return data one cycle after the read strobe. The returned byte is held until the next read.

Top module: `gfx_host_regif`

## Requirements
- R1: After a synchronous active-low reset, every stored register and cache-window read path is cleared: host_rdata, start_pulse, irq_out and all control outputs are 0, and any register reads back 0 except the version byte.
- R2: General register n occupies byte offsets 2n (bits 7:0) and 2n+1 (bits 15:8) for n = 0..15. A host write stores that byte, and a read returns it on host_rdata in the cycle after host_rd.
- R3: A write to offset 0x01F (upper byte of register 15, the program counter) raises start_pulse for the one cycle after the write. In that same cycle it sets the running flag, status bit 5, which reads as bit 5 at offset 0x030. pc_out then shows both latched bytes. A write to 0x01E alone starts nothing.
- R4: The running flag stays set until core_stop is seen. When core_stop and a program-counter upper-byte write arrive in the same cycle, the start wins.
- R5: core_irq sets status bit 15, which reads as bit 7 at offset 0x031. A host read of 0x031 returns the old value and clears the bit on that clock edge. When core_irq coincides with that read, the bit stays set.
- R6: irq_out equals status bit 15 AND NOT configuration bit 7 (offset 0x037, the mask). While the mask is set, irq_out stays 0 even with the bit pending.
- R7: When core_flag_we is high, status bits 1,2,3,4,6,8,9,10,11,12 load from core_flags. Bits 5 and 15 are not affected. Host writes to 0x030/0x031 are ignored.
- R8: Offsets 0x034, 0x036, 0x03C and 0x038 store all 8 bits. Offset 0x037 stores only bits 7 and 5, and bit 5 drives mult_fast. Offset 0x039 bit 0 drives clk_fast. Offset 0x033 bit 0 drives bram_en. All other bits of these bytes read 0.
- R9: Offset 0x03A stores bits 5:0. rom_to_core = bit 4 and ram_to_core = bit 3, where 1 means coprocessor and 0 means host. height_mode = {bit 5, bit 2}, coded 0 = 128, 1 = 160, 2 = 192, 3 = object mode. color_mode = bits 1:0, coded 0 = 4, 1 = 16, 2 = reserved, 3 = 256 colours.
- R10: The cache base is 16 bits at 0x03E (low byte) and 0x03F (high byte). Only bits 15:4 are stored, and bits 3:0 read 0 and show 0 on cache_base.
- R11: Offset 0x03B returns the VERSION parameter (default 0x04), and writes to it are ignored.
- R12: Offsets 0x100 to 0x2FF read and write a 512-byte cache memory, with byte (offset - 0x100) at each address.
- R13: Every other offset (0x020-0x02F, 0x032, 0x035, 0x03D, 0x040-0x0FF, 0x300-0x3FF) reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 10 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after host_rd, held until the next read |
| core_stop | input | 1 | Core has executed a stop; clears the running flag |
| core_irq | input | 1 | Core raises an interrupt |
| core_flag_we | input | 1 | Load core-owned status flags |
| core_flags | input | 16 | Flag values, in status bit positions |
| start_pulse | output | 1 | One-cycle launch request |
| pc_out | output | 16 | Program counter value |
| irq_out | output | 1 | Unmasked interrupt to host |
| rom_to_core | output | 1 | ROM owned by coprocessor |
| ram_to_core | output | 1 | Cartridge RAM owned by coprocessor |
| height_mode | output | 2 | Screen height code |
| color_mode | output | 2 | Colour depth code |
| mult_fast | output | 1 | Fast multiplier select |
| clk_fast | output | 1 | Fast clock select |
| bram_en | output | 1 | Backup RAM enable |
| cache_base | output | 16 | Cache base address, low nibble zero |

## Verification
The hardest case to reach from the ports is the same-cycle collision on the status word. In one collision an interrupt arrives in the very cycle the host acknowledges it. In the other a launch write meets a stop from the core. The bench drives core_irq together with a read of 0x031, and a write to 0x01F together with core_stop, on the same falling edge. It then checks that the flag survived, both through irq_out and through a later read. The masked interrupt is held pending while the mask is set, and the mask is then removed to show that the output follows at once.

// File: rtl/gfx_regif_pkg.sv
// Package: shared constants and types for the coprocessor host register window.
// Assumes a 10-bit byte offset space and 16-bit registers split into bytes.
package gfx_regif_pkg;
    localparam int HOST_AW  = 10;
    localparam int REG_W    = 16;
    localparam int NUM_GPR  = 16;
    localparam int CACHE_BYTES = 512;
    localparam logic [HOST_AW-1:0] CACHE_LO = 10'h100;
    localparam logic [HOST_AW-1:0] CACHE_HI = 10'h2FF;

    // Status word bit positions
    localparam int ST_GO  = 5;
    localparam int ST_IRQ = 15;
    // Bits the core may load: Z,CY,S,OV,R,ALT1,ALT2,IL,IH,B
    localparam logic [REG_W-1:0] CORE_FLAG_MASK = 16'h1F5E;

    // Low-nibble offsets inside the control window 0x030..0x03F
    localparam logic [3:0] C_STAT_LO = 4'h0;
    localparam logic [3:0] C_STAT_HI = 4'h1;
    localparam logic [3:0] C_BRAM    = 4'h3;
    localparam logic [3:0] C_PBANK   = 4'h4;
    localparam logic [3:0] C_RBANK   = 4'h6;
    localparam logic [3:0] C_CFG     = 4'h7;
    localparam logic [3:0] C_SBASE   = 4'h8;
    localparam logic [3:0] C_CLK     = 4'h9;
    localparam logic [3:0] C_SMODE   = 4'hA;
    localparam logic [3:0] C_VER     = 4'hB;
    localparam logic [3:0] C_MBANK   = 4'hC;
    localparam logic [3:0] C_CBASE_L = 4'hE;
    localparam logic [3:0] C_CBASE_H = 4'hF;

    localparam logic [HOST_AW-1:0] STAT_HI_ADDR = 10'h031;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_GPR   = 2'd1,
        RG_CTRL  = 2'd2,
        RG_CACHE = 2'd3
    } region_e;

    // Classify a host byte offset into a region
    function automatic region_e decode_region(input logic [HOST_AW-1:0] a);
        region_e r;
        r = RG_NONE;
        if (a[HOST_AW-1:5] == '0)
            r = RG_GPR;
        else if (a[HOST_AW-1:4] == 6'h03)
            r = RG_CTRL;
        else if (a >= CACHE_LO && a <= CACHE_HI)
            r = RG_CACHE;
        return r;
    endfunction
endpackage

// File: rtl/gfx_gpr_file.sv
// General register file: NUM 16-bit registers, byte-addressed little-endian.
// Assumes at most one write per cycle; the last register is the program
// counter and a write to its upper byte is flagged as a launch.
module gfx_gpr_file #(
    parameter int NUM = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NUM):0]     byte_addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rd_byte,
    output logic                     pc_hi_wr,
    output logic [15:0]              pc_out
);
    localparam int IW = $clog2(NUM);
    localparam logic [IW-1:0] PC_IDX = IW'(NUM - 1);

    logic [15:0]   gpr [NUM];
    logic [IW-1:0] idx;
    logic          hi_sel;

    assign idx    = byte_addr[IW:1];
    assign hi_sel = byte_addr[0];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        // Byte-wise update of one general register
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpr[g] <= '0;
            else if (wr_en && idx == IW'(g)) begin
                if (hi_sel) gpr[g][15:8] <= wdata;
                else        gpr[g][7:0]  <= wdata;
            end
        end
    end

    // Byte select for host reads
    always_comb rd_byte = hi_sel ? gpr[idx][15:8] : gpr[idx][7:0];

    assign pc_hi_wr = wr_en && hi_sel && (idx == PC_IDX);
    assign pc_out   = gpr[NUM-1];
endmodule

// File: rtl/gfx_status_reg.sv
// Status word: running flag, interrupt flag and core-owned arithmetic/mode
// flags. Assumes start beats stop and a new interrupt beats acknowledge.
module gfx_status_reg
    import gfx_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              core_stop,
    input  logic              core_irq,
    input  logic              irq_ack,
    input  logic              flag_we,
    input  logic [REG_W-1:0]  flags,
    output logic [REG_W-1:0]  sfr
);
    logic [REG_W-1:0] sfr_nxt;

    // Next-state of the status word with fixed priorities
    always_comb begin
        sfr_nxt = sfr;
        if (flag_we)
            sfr_nxt = (sfr & ~CORE_FLAG_MASK) | (flags & CORE_FLAG_MASK);
        if (core_stop) sfr_nxt[ST_GO] = 1'b0;
        if (start)     sfr_nxt[ST_GO] = 1'b1;
        if (irq_ack)   sfr_nxt[ST_IRQ] = 1'b0;
        if (core_irq)  sfr_nxt[ST_IRQ] = 1'b1;
    end

    // Status word register
    always_ff @(posedge clk) begin
        if (!rst_n) sfr <= '0;
        else        sfr <= sfr_nxt;
    end
endmodule

// File: rtl/gfx_ctrl_regs.sv
// Control byte bank at 0x030..0x03F: banks, screen base/mode, config, clock,
// backup RAM, version and cache base. Stores only defined bits; status is
// supplied from outside and is read-only here.
module gfx_ctrl_regs
    import gfx_regif_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        ofs,
    input  logic [7:0]        wdata,
    input  logic [REG_W-1:0]  sfr,
    output logic [7:0]        rd_byte,
    output logic              irq_mask,
    output logic              mult_fast,
    output logic              clk_fast,
    output logic              bram_en,
    output logic [5:0]        smode,
    output logic [REG_W-1:0]  cache_base
);
    logic [7:0]  pbank, rbank, mbank, sbase;
    logic [11:0] cbase_q;

    // Writable control bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pbank <= '0; rbank <= '0; mbank <= '0; sbase <= '0;
            irq_mask <= 1'b0; mult_fast <= 1'b0; clk_fast <= 1'b0;
            bram_en <= 1'b0; smode <= '0; cbase_q <= '0;
        end else if (wr_en) begin
            case (ofs)
                C_PBANK:   pbank <= wdata;
                C_RBANK:   rbank <= wdata;
                C_MBANK:   mbank <= wdata;
                C_SBASE:   sbase <= wdata;
                C_CFG: begin
                    irq_mask  <= wdata[7];
                    mult_fast <= wdata[5];
                end
                C_CLK:     clk_fast <= wdata[0];
                C_BRAM:    bram_en  <= wdata[0];
                C_SMODE:   smode    <= wdata[5:0];
                C_CBASE_L: cbase_q[3:0]  <= wdata[7:4];
                C_CBASE_H: cbase_q[11:4] <= wdata;
                default: ;
            endcase
        end
    end

    assign cache_base = {cbase_q, 4'h0};

    // Read mux of the control window
    always_comb begin
        case (ofs)
            C_STAT_LO: rd_byte = sfr[7:0];
            C_STAT_HI: rd_byte = sfr[15:8];
            C_PBANK:   rd_byte = pbank;
            C_RBANK:   rd_byte = rbank;
            C_MBANK:   rd_byte = mbank;
            C_SBASE:   rd_byte = sbase;
            C_CFG:     rd_byte = {irq_mask, 1'b0, mult_fast, 5'b0};
            C_CLK:     rd_byte = {7'b0, clk_fast};
            C_BRAM:    rd_byte = {7'b0, bram_en};
            C_SMODE:   rd_byte = {2'b0, smode};
            C_VER:     rd_byte = VERSION;
            C_CBASE_L: rd_byte = cache_base[7:0];
            C_CBASE_H: rd_byte = cache_base[15:8];
            default:   rd_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/gfx_cache_window.sv
// Byte-wide cache memory seen through the host window. Synchronous write,
// registered read that holds its value between reads.
module gfx_cache_window #(
    parameter int BYTES = 512
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic                      re,
    input  logic [$clog2(BYTES)-1:0]  idx,
    input  logic [7:0]                wdata,
    output logic [7:0]                rdata
);
    logic [7:0] mem [BYTES];

    // Storage array write port
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= 8'h00;
        else if (re) rdata <= mem[idx];
    end
endmodule

// File: rtl/gfx_host_regif.sv
// Top of the host register window. Decodes the byte offset into register,
// control and cache regions, drives the launch pulse and the masked
// interrupt, and returns read data one cycle after the read strobe.
module gfx_host_regif
    import gfx_regif_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h04
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    input  logic                core_stop,
    input  logic                core_irq,
    input  logic                core_flag_we,
    input  logic [REG_W-1:0]    core_flags,
    output logic                start_pulse,
    output logic [REG_W-1:0]    pc_out,
    output logic                irq_out,
    output logic                rom_to_core,
    output logic                ram_to_core,
    output logic [1:0]          height_mode,
    output logic [1:0]          color_mode,
    output logic                mult_fast,
    output logic                clk_fast,
    output logic                bram_en,
    output logic [REG_W-1:0]    cache_base
);
    localparam int GBW = $clog2(NUM_GPR) + 1;
    localparam int CAW = $clog2(CACHE_BYTES);

    region_e           region;
    logic [7:0]        gpr_byte, ctrl_byte, cache_byte, misc_d, misc_q;
    logic              pc_hi_wr, irq_mask, sel_cache_q;
    logic [REG_W-1:0]  sfr;
    logic [5:0]        smode;
    logic [CAW-1:0]    cidx;

    assign region = decode_region(host_addr);
    assign cidx   = host_addr[CAW-1:0] - CACHE_LO[CAW-1:0];

    gfx_gpr_file #(.NUM(NUM_GPR)) u_gpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr && region == RG_GPR),
        .byte_addr(host_addr[GBW-1:0]),
        .wdata    (host_wdata),
        .rd_byte  (gpr_byte),
        .pc_hi_wr (pc_hi_wr),
        .pc_out   (pc_out)
    );

    gfx_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pc_hi_wr),
        .core_stop(core_stop),
        .core_irq (core_irq),
        .irq_ack  (host_rd && host_addr == STAT_HI_ADDR),
        .flag_we  (core_flag_we),
        .flags    (core_flags),
        .sfr      (sfr)
    );

    gfx_ctrl_regs #(.VERSION(VERSION)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr && region == RG_CTRL),
        .ofs       (host_addr[3:0]),
        .wdata     (host_wdata),
        .sfr       (sfr),
        .rd_byte   (ctrl_byte),
        .irq_mask  (irq_mask),
        .mult_fast (mult_fast),
        .clk_fast  (clk_fast),
        .bram_en   (bram_en),
        .smode     (smode),
        .cache_base(cache_base)
    );

    gfx_cache_window #(.BYTES(CACHE_BYTES)) u_cache (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (host_wr && region == RG_CACHE),
        .re   (host_rd && region == RG_CACHE),
        .idx  (cidx),
        .wdata(host_wdata),
        .rdata(cache_byte)
    );

    // Non-cache read source for the current offset
    always_comb begin
        case (region)
            RG_GPR:  misc_d = gpr_byte;
            RG_CTRL: misc_d = ctrl_byte;
            default: misc_d = 8'h00;
        endcase
    end

    // Read capture and one-cycle launch pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misc_q      <= 8'h00;
            sel_cache_q <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= pc_hi_wr;
            if (host_rd) begin
                misc_q      <= misc_d;
                sel_cache_q <= (region == RG_CACHE);
            end
        end
    end

    assign host_rdata  = sel_cache_q ? cache_byte : misc_q;
    assign irq_out     = sfr[ST_IRQ] && !irq_mask;
    assign rom_to_core = smode[4];
    assign ram_to_core = smode[3];
    assign height_mode = {smode[5], smode[2]};
    assign color_mode  = smode[1:0];
endmodule

// File: rtl/gfx_host_regif_chk.sv
// Property checker for the host register window, bound to the top module.
module gfx_host_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  host_addr,
    input logic        host_wr,
    input logic        host_rd,
    input logic        core_stop,
    input logic        core_irq,
    input logic        start_pulse,
    input logic        irq_out,
    input logic [15:0] sfr
);
    // R3
    start_from_pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(host_wr && host_addr == 10'h01F));
    // R3
    start_sets_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> sfr[5]);
    // R4
    go_falls_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sfr[5]) |-> $past(core_stop));
    // R5
    irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |=> sfr[15]);
    // R5
    read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 10'h031 && !core_irq) |=> !sfr[15]);
    // R6
    irq_out_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> sfr[15]);
endmodule

bind gfx_host_regif gfx_host_regif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .core_stop  (core_stop),
    .core_irq   (core_irq),
    .start_pulse(start_pulse),
    .irq_out    (irq_out),
    .sfr        (sfr)
);

// File: tb/sim_gfx_host_regif.sv
module sim_gfx_host_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        core_stop = 1'b0, core_irq = 1'b0, core_flag_we = 1'b0;
    logic [15:0] core_flags = '0;
    logic        start_pulse, irq_out, rom_to_core, ram_to_core;
    logic        mult_fast, clk_fast, bram_en;
    logic [15:0] pc_out, cache_base;
    logic [1:0]  height_mode, color_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gfx_host_regif u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_stop(core_stop), .core_irq(core_irq), .core_flag_we(core_flag_we),
        .core_flags(core_flags), .start_pulse(start_pulse), .pc_out(pc_out),
        .irq_out(irq_out), .rom_to_core(rom_to_core), .ram_to_core(ram_to_core),
        .height_mode(height_mode), .color_mode(color_mode), .mult_fast(mult_fast),
        .clk_fast(clk_fast), .bram_en(bram_en), .cache_base(cache_base)
    );

    // Vector fields: [29:26] requirement, [25:16] offset, [15:8] write, [7:0] expected read
    localparam int NVEC = 23;
    localparam logic [29:0] VEC [NVEC] = '{
        {4'd2,  10'h004, 8'h5A, 8'h5A},   // R2
        {4'd2,  10'h005, 8'hC3, 8'hC3},   // R2
        {4'd2,  10'h01C, 8'h77, 8'h77},   // R2
        {4'd11, 10'h03B, 8'h55, 8'h04},   // R11
        {4'd8,  10'h037, 8'hFF, 8'hA0},   // R8
        {4'd8,  10'h039, 8'hFF, 8'h01},   // R8
        {4'd8,  10'h033, 8'hFF, 8'h01},   // R8
        {4'd8,  10'h034, 8'h12, 8'h12},   // R8
        {4'd8,  10'h036, 8'h34, 8'h34},   // R8
        {4'd8,  10'h03C, 8'h56, 8'h56},   // R8
        {4'd8,  10'h038, 8'h78, 8'h78},   // R8
        {4'd9,  10'h03A, 8'hFF, 8'h3F},   // R9
        {4'd10, 10'h03E, 8'hFF, 8'hF0},   // R10
        {4'd10, 10'h03F, 8'hAB, 8'hAB},   // R10
        {4'd13, 10'h020, 8'hFF, 8'h00},   // R13
        {4'd13, 10'h032, 8'hFF, 8'h00},   // R13
        {4'd13, 10'h035, 8'hFF, 8'h00},   // R13
        {4'd13, 10'h03D, 8'hFF, 8'h00},   // R13
        {4'd13, 10'h0FF, 8'hFF, 8'h00},   // R13
        {4'd13, 10'h300, 8'hFF, 8'h00},   // R13
        {4'd7,  10'h030, 8'hFF, 8'h00},   // R7 host write to status ignored
        {4'd12, 10'h100, 8'h11, 8'h11},   // R12
        {4'd12, 10'h2FF, 8'hEE, 8'hEE}    // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [9:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic pulse_core(input bit stop, input bit irq);
        @(negedge clk);
        core_stop = stop; core_irq = irq;
        @(negedge clk);
        core_stop = 1'b0; core_irq = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", {24'h0, host_rdata}, 32'h0);
        check("R1 start/irq", {30'h0, start_pulse, irq_out}, 32'h0);
        check("R1 outputs", {16'h0, cache_base}, 32'h0);
        rst_n = 1'b1;
        rd_chk("R1 version", 10'h03B, 8'h04);
        rd_chk("R1 status", 10'h030, 8'h00);

        // Table of write-then-read vectors
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] d;
            wr(VEC[i][25:16], VEC[i][15:8]);
            rd(VEC[i][25:16], d);
            check($sformatf("R%0d vec%0d", VEC[i][29:26], i), {24'h0, d}, {24'h0, VEC[i][7:0]});
        end

        // R8 outputs
        check("R8 mult_fast", {31'h0, mult_fast}, 32'h1);
        check("R8 clk_fast/bram_en", {30'h0, clk_fast, bram_en}, 32'h3);
        // R9 mode decoding
        check("R9 mode 3F", {26'h0, rom_to_core, ram_to_core, height_mode, color_mode}, {26'h0, 6'b11_11_11});
        wr(10'h03A, 8'h24);
        check("R9 mode 24", {26'h0, rom_to_core, ram_to_core, height_mode, color_mode}, {26'h0, 6'b00_11_00});
        wr(10'h03A, 8'h1B);
        check("R9 mode 1B", {26'h0, rom_to_core, ram_to_core, height_mode, color_mode}, {26'h0, 6'b11_00_11});
        // R10 cache base output
        check("R10 cache_base", {16'h0, cache_base}, 32'h0000ABF0);

        // R3 launch
        wr(10'h01E, 8'h34);
        check("R3 no start on low byte", {31'h0, start_pulse}, 32'h0);
        rd_chk("R3 go clear", 10'h030, 8'h00);
        @(negedge clk);
        host_addr = 10'h01F; host_wdata = 8'h12; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        check("R3 start pulse", {31'h0, start_pulse}, 32'h1);
        check("R3 pc_out", {16'h0, pc_out}, 32'h1234);
        @(negedge clk);
        check("R3 pulse one cycle", {31'h0, start_pulse}, 32'h0);
        rd_chk("R3 go set", 10'h030, 8'h20);

        // R4 go held until stop
        repeat (5) @(negedge clk);
        rd_chk("R4 go held", 10'h030, 8'h20);
        pulse_core(1'b1, 1'b0);
        rd_chk("R4 stop clears go", 10'h030, 8'h00);
        @(negedge clk);
        host_addr = 10'h01F; host_wdata = 8'h12; host_wr = 1'b1; core_stop = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; core_stop = 1'b0;
        rd_chk("R4 start beats stop", 10'h030, 8'h20);
        pulse_core(1'b1, 1'b0);

        // R7 core flag load
        @(negedge clk);
        core_flags = 16'hFFFF; core_flag_we = 1'b1;
        @(negedge clk);
        core_flag_we = 1'b0;
        rd_chk("R7 flags low", 10'h030, 8'h5E);
        rd_chk("R7 flags high", 10'h031, 8'h1F);
        @(negedge clk);
        core_flags = 16'h0000; core_flag_we = 1'b1;
        @(negedge clk);
        core_flag_we = 1'b0;
        rd_chk("R7 flags cleared", 10'h030, 8'h00);

        // R6 masked interrupt (mask set by table write of 0xFF to 0x037)
        pulse_core(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            check("R6 masked irq_out", {31'h0, irq_out}, 32'h0);
            @(negedge clk);
        end
        wr(10'h037, 8'h00);
        check("R6 unmask shows pending", {31'h0, irq_out}, 32'h1);
        check("R8 mult_fast cleared", {31'h0, mult_fast}, 32'h0);
        // R5 acknowledge by read
        rd_chk("R5 irq read", 10'h031, 8'h80);
        check("R5 cleared after read", {31'h0, irq_out}, 32'h0);
        rd_chk("R5 irq gone", 10'h031, 8'h00);
        pulse_core(1'b0, 1'b1);
        check("R6 irq_out unmasked", {31'h0, irq_out}, 32'h1);
        rd_chk("R5 ack", 10'h031, 8'h80);
        // R5 new interrupt coincident with acknowledge
        @(negedge clk);
        host_addr = 10'h031; host_rd = 1'b1; core_irq = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; core_irq = 1'b0;
        check("R5 coincident old value", {24'h0, host_rdata}, 32'h0);
        check("R5 set beats ack", {31'h0, irq_out}, 32'h1);
        rd_chk("R5 still pending", 10'h031, 8'h80);

        // R12 cache contents persist
        rd_chk("R12 cache reread", 10'h100, 8'h11);
        wr(10'h1AB, 8'h3C);
        rd_chk("R12 cache mid", 10'h1AB, 8'h3C);
        rd_chk("R2 gpr persist", 10'h005, 8'hC3);

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1 cfg after reset", 10'h037, 8'h00);
        rd_chk("R1 gpr after reset", 10'h004, 8'h00);
        check("R1 outputs after reset", {16'h0, cache_base}, 32'h0);

        finish_run();
    end
endmodule